// File: doc/BRIEF.md
# Debug Register Bank with Watchpoint Comparators

This block is the register file that an on-chip debug controller reaches through a 5-bit register index. It keeps a small debug control field, a debug status field, and a control/data pair for a host communications channel. It also keeps one set of registers for each watchpoint comparator. A register port with index, write data and write strobe lets the controller program every register. Read data is combinational and follows the index in the same cycle. A write lands on the rising clock edge.

Each watchpoint comparator watches the live bus address, bus data and an 8-bit access-attribute vector. It sets its hit output while every unmasked bit equals the programmed value and its arm bit is set. Each comparison field has its own mask register. A mask bit of 1 removes that bit from the comparison. The arm bit is bit 8 of the control value register. It has no mask bit, so it is always in effect. Index values that hold no register read as zero, and writes to them are dropped.

Top module: `dbg_regbank`

## Requirements
- R1: After reset every register reads back zero and no hit output is set.
- R2: Index 0x00 holds a 6-bit debug control field. A write keeps wdata[5:0], and a read returns the field zero-extended to 32 bits.
- R3: Index 0x01 holds a 5-bit debug status field. A write keeps wdata[4:0], and a read returns the field zero-extended.
- R4: Index 0x04 holds the channel control register and index 0x05 holds the channel data register. Both are 32 bits wide and read back exactly what was last written.
- R5: Comparator 0 sits at indices 0x08 to 0x0D. The slot order is address value (32 bits), address mask (32), data value (32), data mask (32), control value (9, bit 8 is the arm bit) and control mask (8). Narrow slots keep the low bits of a write and read back zero-extended.
- R6: Comparator 1 uses the same slot layout at indices 0x10 to 0x15.
- R7: Every other index (0x02, 0x03, 0x06, 0x07, 0x0E, 0x0F and 0x16 to 0x1F) reads zero. A write to one of them changes no register.
- R8: A comparator's hit output can be 1 only while its arm bit (control value bit 8) is 1.
- R9: An armed comparator hits while ((bus_addr ^ addr_value) & ~addr_mask) == 0 and ((bus_data ^ data_value) & ~data_mask) == 0. A mask bit of 1 excludes that bit from the comparison.
- R10: Attribute bits are compared against control value bits [7:0] under control mask bits [7:0], using the same polarity. A full control mask of 0xFF does not bypass the arm bit.
- R11: The two comparators are independent. Programming one does not change the other's hit output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 5 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Write strobe, register written at the next rising edge |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| bus_addr | input | 32 | Live bus address being watched |
| bus_data | input | 32 | Live bus data being watched |
| bus_attr | input | 8 | Live access-attribute bits being watched |
| wp_hit | output | 2 | Per-comparator match, bit k for comparator k |

## Verification
The bench builds the block with its defaults: 32-bit data, 8 attribute bits, two comparators, and the mask polarity where 1 means ignore. With two comparators the index space has 0x16 to 0x1F left empty as well as the gaps inside the map, so every kind of unmapped index can be hit. Bus values are drawn close to the programmed values with occasional single-bit flips. This exercises the edges of the masked comparison, which pure random traffic would almost never reach.

// File: rtl/dbg_regbank_pkg.sv
package dbg_regbank_pkg;

   localparam int unsigned IDX_W = 5;

   // fixed indices of the shared registers
   localparam logic [IDX_W-1:0] IDX_DBG_CTRL = 5'h00;
   localparam logic [IDX_W-1:0] IDX_DBG_STAT = 5'h01;
   localparam logic [IDX_W-1:0] IDX_CH_CTRL  = 5'h04;
   localparam logic [IDX_W-1:0] IDX_CH_DATA  = 5'h05;

   // slot order inside one comparator window
   typedef enum logic [2:0] {
      SLOT_ADDR_VAL = 3'd0,
      SLOT_ADDR_MSK = 3'd1,
      SLOT_DATA_VAL = 3'd2,
      SLOT_DATA_MSK = 3'd3,
      SLOT_CTL_VAL  = 3'd4,
      SLOT_CTL_MSK  = 3'd5
   } wp_slot_e;

   localparam int unsigned MAX_WP = 3;

   // comparator k occupies the 8-entry window starting at (k+1)*8
   function automatic logic [IDX_W-1:0] wp_base(input int unsigned k);
      return IDX_W'((k + 1) * 8);
   endfunction

   function automatic logic idx_mapped(input logic [IDX_W-1:0] a,
                                       input int unsigned nwp);
      logic hit;
      hit = (a == IDX_DBG_CTRL) || (a == IDX_DBG_STAT) ||
            (a == IDX_CH_CTRL)  || (a == IDX_CH_DATA);
      for (int unsigned k = 0; k < MAX_WP; k++) begin
         if (k < nwp && a[IDX_W-1:3] == wp_base(k)[IDX_W-1:3] && a[2:0] <= 3'd5)
            hit = 1'b1;
      end
      return hit;
   endfunction

endpackage

// File: rtl/dbg_masked_eq.sv
module dbg_masked_eq #(
   parameter int unsigned W          = 32,
   parameter bit          ONE_IGNORES = 1'b1
) (
   input  logic [W-1:0] value,
   input  logic [W-1:0] mask,
   input  logic [W-1:0] live,
   output logic         equal
);

   logic [W-1:0] care;

   generate
      if (ONE_IGNORES) begin : g_pol_ignore
         assign care = ~mask;
      end else begin : g_pol_select
         assign care = mask;
      end
   endgenerate

   assign equal = ((value ^ live) & care) == '0;

endmodule

// File: rtl/dbg_core_regs.sv
module dbg_core_regs
   import dbg_regbank_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CTRL_W = 6,
   parameter int unsigned STAT_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  sel_idx,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);

   logic [CTRL_W-1:0] ctrl_q;
   logic [STAT_W-1:0] stat_q;
   logic [DATA_W-1:0] ch_ctrl_q;
   logic [DATA_W-1:0] ch_data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         stat_q    <= '0;
         ch_ctrl_q <= '0;
         ch_data_q <= '0;
      end else if (wr_en) begin
         case (sel_idx)
            IDX_DBG_CTRL: ctrl_q    <= wr_data[CTRL_W-1:0];
            IDX_DBG_STAT: stat_q    <= wr_data[STAT_W-1:0];
            IDX_CH_CTRL:  ch_ctrl_q <= wr_data;
            IDX_CH_DATA:  ch_data_q <= wr_data;
            default: ;
         endcase
      end
   end

   always_comb begin
      rd_data = '0;
      case (sel_idx)
         IDX_DBG_CTRL: rd_data = DATA_W'(ctrl_q);
         IDX_DBG_STAT: rd_data = DATA_W'(stat_q);
         IDX_CH_CTRL:  rd_data = ch_ctrl_q;
         IDX_CH_DATA:  rd_data = ch_data_q;
         default:      rd_data = '0;
      endcase
   end

endmodule

// File: rtl/dbg_wp_unit.sv
module dbg_wp_unit
   import dbg_regbank_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ATTR_W      = 8,
   parameter int unsigned UNIT        = 0,
   parameter bit          ONE_IGNORES = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  sel_idx,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_data,
   input  logic [ATTR_W-1:0] bus_attr,
   output logic [DATA_W-1:0] rd_data,
   output logic              armed,
   output logic              hit
);

   localparam logic [IDX_W-1:0] BASE = wp_base(UNIT);

   logic [DATA_W-1:0] addr_val_q, addr_msk_q;
   logic [DATA_W-1:0] data_val_q, data_msk_q;
   logic [ATTR_W:0]   ctl_val_q;
   logic [ATTR_W-1:0] ctl_msk_q;

   logic     in_window;
   wp_slot_e slot;
   logic     eq_addr, eq_data, eq_attr;

   assign in_window = (sel_idx[IDX_W-1:3] == BASE[IDX_W-1:3]);
   assign slot      = wp_slot_e'(sel_idx[2:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_val_q <= '0;
         addr_msk_q <= '0;
         data_val_q <= '0;
         data_msk_q <= '0;
         ctl_val_q  <= '0;
         ctl_msk_q  <= '0;
      end else if (wr_en && in_window) begin
         case (slot)
            SLOT_ADDR_VAL: addr_val_q <= wr_data;
            SLOT_ADDR_MSK: addr_msk_q <= wr_data;
            SLOT_DATA_VAL: data_val_q <= wr_data;
            SLOT_DATA_MSK: data_msk_q <= wr_data;
            SLOT_CTL_VAL:  ctl_val_q  <= wr_data[ATTR_W:0];
            SLOT_CTL_MSK:  ctl_msk_q  <= wr_data[ATTR_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      rd_data = '0;
      if (in_window) begin
         case (slot)
            SLOT_ADDR_VAL: rd_data = addr_val_q;
            SLOT_ADDR_MSK: rd_data = addr_msk_q;
            SLOT_DATA_VAL: rd_data = data_val_q;
            SLOT_DATA_MSK: rd_data = data_msk_q;
            SLOT_CTL_VAL:  rd_data = DATA_W'(ctl_val_q);
            SLOT_CTL_MSK:  rd_data = DATA_W'(ctl_msk_q);
            default:       rd_data = '0;
         endcase
      end
   end

   dbg_masked_eq #(.W(DATA_W), .ONE_IGNORES(ONE_IGNORES)) u_eq_addr (
      .value(addr_val_q), .mask(addr_msk_q), .live(bus_addr), .equal(eq_addr)
   );

   dbg_masked_eq #(.W(DATA_W), .ONE_IGNORES(ONE_IGNORES)) u_eq_data (
      .value(data_val_q), .mask(data_msk_q), .live(bus_data), .equal(eq_data)
   );

   dbg_masked_eq #(.W(ATTR_W), .ONE_IGNORES(ONE_IGNORES)) u_eq_attr (
      .value(ctl_val_q[ATTR_W-1:0]), .mask(ctl_msk_q), .live(bus_attr), .equal(eq_attr)
   );

   // the top control-value bit arms the unit and has no mask bit
   assign armed = ctl_val_q[ATTR_W];
   assign hit   = armed & eq_addr & eq_data & eq_attr;

endmodule

// File: rtl/dbg_regbank.sv
module dbg_regbank
   import dbg_regbank_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ATTR_W      = 8,
   parameter int unsigned NUM_WP      = 2,
   parameter int unsigned CTRL_W      = 6,
   parameter int unsigned STAT_W      = 5,
   parameter bit          ONE_IGNORES = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [4:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              reg_we,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [DATA_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_data,
   input  logic [ATTR_W-1:0] bus_attr,
   output logic [NUM_WP-1:0] wp_hit
);

   // elaboration-time parameter checks
   generate
      if (NUM_WP < 1 || NUM_WP > MAX_WP) begin : g_bad_num_wp
         $error("dbg_regbank: NUM_WP must lie in 1..3");
      end
      if (ATTR_W + 1 > DATA_W) begin : g_bad_attr_w
         $error("dbg_regbank: ATTR_W+1 must fit in DATA_W");
      end
      if (CTRL_W > DATA_W || STAT_W > DATA_W || CTRL_W < 1 || STAT_W < 1) begin : g_bad_core_w
         $error("dbg_regbank: control/status widths must lie in 1..DATA_W");
      end
   endgenerate

   logic [DATA_W-1:0] core_rd;
   logic [DATA_W-1:0] unit_rd [NUM_WP];
   logic [NUM_WP-1:0] wp_armed;

   dbg_core_regs #(
      .DATA_W(DATA_W), .CTRL_W(CTRL_W), .STAT_W(STAT_W)
   ) u_core (
      .clk(clk), .rst_n(rst_n), .sel_idx(reg_addr), .wr_en(reg_we),
      .wr_data(reg_wdata), .rd_data(core_rd)
   );

   generate
      for (genvar k = 0; k < NUM_WP; k++) begin : g_wp
         dbg_wp_unit #(
            .DATA_W(DATA_W), .ATTR_W(ATTR_W), .UNIT(k), .ONE_IGNORES(ONE_IGNORES)
         ) u_wp (
            .clk(clk), .rst_n(rst_n), .sel_idx(reg_addr), .wr_en(reg_we),
            .wr_data(reg_wdata), .bus_addr(bus_addr), .bus_data(bus_data),
            .bus_attr(bus_attr), .rd_data(unit_rd[k]), .armed(wp_armed[k]),
            .hit(wp_hit[k])
         );
      end
   endgenerate

   // each source drives zero unless its own index is selected
   always_comb begin
      reg_rdata = core_rd;
      for (int i = 0; i < NUM_WP; i++) reg_rdata = reg_rdata | unit_rd[i];
   end

endmodule

// File: rtl/dbg_regbank_chk.sv
module dbg_regbank_chk
   import dbg_regbank_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ATTR_W = 8,
   parameter int unsigned NUM_WP = 2,
   parameter int unsigned CTRL_W = 6,
   parameter int unsigned STAT_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic [4:0]        reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic              reg_we,
   input logic [DATA_W-1:0] reg_rdata,
   input logic [NUM_WP-1:0] wp_hit,
   input logic [NUM_WP-1:0] wp_armed
);

   AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !idx_mapped(reg_addr, NUM_WP) |-> reg_rdata == '0); // R7

   AST_CTRL_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      reg_addr == IDX_DBG_CTRL |-> reg_rdata[DATA_W-1:CTRL_W] == '0); // R2

   AST_STAT_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      reg_addr == IDX_DBG_STAT |-> reg_rdata[DATA_W-1:STAT_W] == '0); // R3

   AST_CHAN_DATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == IDX_CH_DATA) ##1 (reg_addr == IDX_CH_DATA)
      |-> reg_rdata == $past(reg_wdata)); // R4

   generate
      for (genvar k = 0; k < NUM_WP; k++) begin : g_unit_chk
         AST_HIT_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
            wp_hit[k] |-> wp_armed[k]); // R8

         AST_ARM_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && reg_addr == (wp_base(k) + 5'd4))
            |=> wp_armed[k] == $past(reg_wdata[ATTR_W])); // R5

         AST_CTLVAL_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
            reg_addr == (wp_base(k) + 5'd4) |-> reg_rdata[DATA_W-1:ATTR_W+1] == '0); // R5

         AST_CTLMSK_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
            reg_addr == (wp_base(k) + 5'd5) |-> reg_rdata[DATA_W-1:ATTR_W] == '0); // R5
      end
   endgenerate

endmodule

bind dbg_regbank dbg_regbank_chk #(
   .DATA_W(DATA_W), .ATTR_W(ATTR_W), .NUM_WP(NUM_WP), .CTRL_W(CTRL_W), .STAT_W(STAT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
   .reg_we(reg_we), .reg_rdata(reg_rdata), .wp_hit(wp_hit), .wp_armed(wp_armed)
);

// File: tb/tb_dbg_regbank.sv
`timescale 1ns/1ps
module tb_dbg_regbank;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_rdata;
   logic [31:0] bus_addr = '0;
   logic [31:0] bus_data = '0;
   logic [7:0]  bus_attr = '0;
   logic [1:0]  wp_hit;

   int n_checks = 0;
   int n_fail   = 0;
   string rd_tag_force = "";

   // behavioural model: one word per index, width looked up per index
   logic [31:0] mdl [32];

   always #2 clk = ~clk;   // 250 MHz

   dbg_regbank dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_we(reg_we), .reg_rdata(reg_rdata), .bus_addr(bus_addr),
      .bus_data(bus_data), .bus_attr(bus_attr), .wp_hit(wp_hit)
   );

   function automatic int width_of(input int a);
      if (a == 0) return 6;
      if (a == 1) return 5;
      if (a == 4 || a == 5) return 32;
      if ((a >= 8 && a <= 13) || (a >= 16 && a <= 21)) begin
         case (a % 8)
            4: return 9;
            5: return 8;
            default: return 32;
         endcase
      end
      return 0;
   endfunction

   function automatic logic [31:0] wmask(input int a);
      int w = width_of(a);
      if (w == 0) return 32'h0;
      if (w == 32) return 32'hFFFF_FFFF;
      return (32'h1 << w) - 32'h1;
   endfunction

   function automatic string tag_of(input int a);
      if (rd_tag_force != "") return rd_tag_force;
      if (width_of(a) == 0) return "R7";
      if (a == 0) return "R2";
      if (a == 1) return "R3";
      if (a < 8) return "R4";
      if (a < 16) return "R5";
      return "R6";
   endfunction

   function automatic logic model_hit(input int u);
      int b = (u + 1) * 8;
      logic ok;
      ok = mdl[b+4][8];
      ok = ok && (((bus_addr ^ mdl[b]) & ~mdl[b+1]) == 0);
      ok = ok && (((bus_data ^ mdl[b+2]) & ~mdl[b+3]) == 0);
      ok = ok && ((({24'h0, bus_attr} ^ mdl[b+4]) & ~mdl[b+5] & 32'hFF) == 0);
      return ok;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 32; i++) mdl[i] = '0;
      end else if (reg_we) begin
         mdl[reg_addr] = reg_wdata & wmask(reg_addr);
      end
   end

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // one clock, then compare every output with the model away from the edge
   task automatic cyc(input string hit_tag = "R9");
      @(posedge clk);
      @(negedge clk);
      check(reg_rdata, mdl[reg_addr] & wmask(reg_addr), tag_of(reg_addr));
      check({30'h0, wp_hit}, {30'h0, model_hit(1), model_hit(0)}, hit_tag);
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      reg_addr = 5'(a); reg_wdata = d; reg_we = 1'b1;
      cyc();
      reg_we = 1'b0;
   endtask

   task automatic expect_hit(input logic [1:0] exp, input string tag);
      cyc(tag);
      check({30'h0, wp_hit}, {30'h0, exp}, tag);
   endtask

   initial begin
      for (int i = 0; i < 32; i++) mdl[i] = '0;
      repeat (3) cyc("R1");
      rst_n = 1'b1;

      // R1: every index reads zero after reset, no hit
      rd_tag_force = "R1";
      for (int a = 0; a < 32; a++) begin
         reg_addr = 5'(a);
         cyc("R1");
         check(reg_rdata, 32'h0, "R1");
      end
      check({30'h0, wp_hit}, 32'h0, "R1");
      rd_tag_force = "";

      // R2..R7: all ones everywhere, read back through the model widths
      for (int a = 0; a < 32; a++) wr(a, 32'hFFFF_FFFF);
      for (int a = 0; a < 32; a++) begin reg_addr = 5'(a); cyc(); end
      reg_addr = 5'h00; cyc(); check(reg_rdata, 32'h0000_003F, "R2");
      reg_addr = 5'h01; cyc(); check(reg_rdata, 32'h0000_001F, "R3");
      reg_addr = 5'h0C; cyc(); check(reg_rdata, 32'h0000_01FF, "R5");
      reg_addr = 5'h15; cyc(); check(reg_rdata, 32'h0000_00FF, "R6");
      for (int a = 0; a < 32; a++) wr(a, 32'hA55A_3CC3 ^ (32'h0101_0101 * a));
      for (int a = 0; a < 32; a++) begin reg_addr = 5'(a); cyc(); end
      reg_addr = 5'h05; cyc(); check(reg_rdata, 32'hA55A_3CC3 ^ (32'h0101_0101 * 5), "R4");

      // R7: writes to holes leave the mapped neighbours intact
      wr(5'h00, 32'h15); wr(5'h0D, 32'h5A);
      wr(5'h0E, 32'hFFFF_FFFF); wr(5'h02, 32'hFFFF_FFFF); wr(5'h1F, 32'hFFFF_FFFF);
      reg_addr = 5'h0E; cyc(); check(reg_rdata, 32'h0, "R7");
      reg_addr = 5'h00; cyc(); check(reg_rdata, 32'h15, "R7");
      reg_addr = 5'h0D; cyc(); check(reg_rdata, 32'h5A, "R7");

      // comparator 0 directed program
      wr(8,  32'h1000_0040); wr(9,  32'h0000_000F);
      wr(10, 32'hDEAD_BEEF); wr(11, 32'hFFFF_0000);
      wr(12, 32'h0000_0125); wr(13, 32'h0000_00F0);
      wr(16, 32'h0); wr(17, 32'h0); wr(18, 32'h0); wr(19, 32'h0);
      wr(20, 32'h0); wr(21, 32'h0);
      bus_addr = 32'h1000_0047; bus_data = 32'h1234_BEEF; bus_attr = 8'h35;
      expect_hit(2'b01, "R9");                 // masked bits differ only
      bus_addr = 32'h1000_0050;
      expect_hit(2'b00, "R9");                 // unmasked address bit differs
      bus_addr = 32'h1000_0047; bus_data = 32'h1234_BEEE;
      expect_hit(2'b00, "R9");                 // unmasked data bit differs
      bus_data = 32'h1234_BEEF; bus_attr = 8'h24;
      expect_hit(2'b00, "R10");                // unmasked attribute bit differs
      bus_attr = 8'hC5;
      expect_hit(2'b01, "R10");                // masked attribute bits differ only
      wr(13, 32'hFF); wr(12, 32'h0000_0025);
      expect_hit(2'b00, "R8");                 // disarmed, full attribute mask
      wr(12, 32'h0000_0125);
      expect_hit(2'b01, "R10");

      // R11: arm comparator 1 with all-ignore masks, comparator 0 unaffected
      wr(17, 32'hFFFF_FFFF); wr(19, 32'hFFFF_FFFF); wr(21, 32'hFF);
      wr(20, 32'h100);
      expect_hit(2'b11, "R11");
      bus_addr = 32'h0;
      expect_hit(2'b10, "R11");
      wr(20, 32'h0);
      expect_hit(2'b00, "R8");

      // mixed traffic, bus values steered near the programmed values
      for (int n = 0; n < 600; n++) begin
         int u = $urandom % 2;
         int b = (u + 1) * 8;
         reg_we    = ($urandom % 4) == 0;
         reg_addr  = 5'($urandom);
         reg_wdata = $urandom;
         if (reg_we && (reg_addr[2:0] == 3'd1 || reg_addr[2:0] == 3'd3))
            reg_wdata = reg_wdata & $urandom & $urandom;
         if (reg_we && reg_addr[2:0] == 3'd4) reg_wdata[8] = ($urandom % 4) != 0;
         bus_addr = (mdl[b]   & ~mdl[b+1]) | ($urandom & mdl[b+1]);
         bus_data = (mdl[b+2] & ~mdl[b+3]) | ($urandom & mdl[b+3]);
         bus_attr = 8'((mdl[b+4] & ~mdl[b+5]) | ($urandom & mdl[b+5]));
         if (($urandom % 4) == 0) bus_addr[$urandom % 32] ^= 1'b1;
         if (($urandom % 6) == 0) bus_attr[$urandom % 8] ^= 1'b1;
         cyc("R9");
      end
      reg_we = 1'b0;

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule